// File: doc/BRIEF.md
# Cell-Granular Byte Interface with Three-Cell Buffers

This block sits between an ATM-layer device and the line-coding logic of a physical-layer port. It uses an 8-bit, cell-oriented handshake toward the ATM layer. In the transmit direction, the ATM layer pushes 53-byte cells with an enable, a start-of-cell marker, a data byte and an odd-parity bit. The block stores up to three whole cells and hands the bytes one at a time to a line-side consumer through a valid/ready stream. The consumer may hold `ln_tx_ready` low for any number of cycles. While it does, the offered byte and its start-of-packet marker stay frozen.

In the receive direction, a line-side producer pushes bytes with a start marker through a valid/ready stream. The block accepts bytes whenever it has a free cell slot and back-pressures only when all three slots hold complete cells. Whole cells are then released to the ATM layer, one byte for each clock edge on which `rx_en` is high. While the line's good-signal input is low, the receive path takes every byte offered and throws it away, so the line side never stalls on a dead link.

Both cell-available flags count whole cells. Transmit parity errors and truncated cells are recorded in sticky status bits, and a synchronous reset clears them.

Top module: `utopia_cell_if`

## Requirements
- R1: While `rst` is high at a clock edge, both buffers empty and both sticky bits clear. After that edge `tx_cav`=1, `rx_cav`=0, `ln_tx_valid`=0, `rx_data`=0, `rx_soc`=0 and `rx_par`=1.
- R2: A transmit cell is 53 bytes. The first byte carries `tx_soc`=1, and a byte is taken only on an edge with `tx_en`=1. Stored cells leave on `ln_tx_data` in arrival order, with `ln_tx_sop`=1 on byte 0 only. A byte moves on each edge where `ln_tx_valid` and `ln_tx_ready` are both high, and `ln_tx_valid` rises only once a whole cell is stored.
- R3: `tx_cav` is 1 exactly when the number of complete stored cells, plus one if a cell is partly written, is below 3.
- R4: A start marker (`tx_soc`, or `ln_rx_sop` on the receive side) that arrives before 53 bytes of the current cell have been taken discards the partial cell, sets `runt_seen`, and starts a new cell with that byte. A byte without a start marker that arrives while no cell is open is dropped.
- R5: Parity is odd: data bits plus parity bit hold an odd number of ones. A taken transmit byte that breaks this rule sets `par_err`, and the byte is still stored and delivered unchanged. `irq` equals `par_err` AND `par_irq_en`.
- R6: While `ln_tx_valid`=1 and `ln_tx_ready`=0, `ln_tx_data` and `ln_tx_sop` hold their values and `ln_tx_valid` stays 1.
- R7: When 3 complete cells are stored on the transmit side, further transmit bytes are dropped and never reach the line.
- R8: With `sig_good`=1, `ln_rx_ready` is 0 exactly when 3 complete cells are stored on the receive side. Receive bytes are taken only on edges with `ln_rx_valid` and `ln_rx_ready` both high.
- R9: `rx_cav` is 1 exactly when at least one complete received cell has not had its byte 0 transferred.
- R10: On an edge with `rx_en`=1 while a complete cell's byte is pending, that byte appears on `rx_data` after the edge. `rx_soc`=1 is set only for byte 0, and `rx_par` is the odd parity of `rx_data`. On any other edge, `rx_data`, `rx_soc` and `rx_par` hold.
- R11: While `sig_good`=0, `ln_rx_ready`=1. Every offered byte is discarded and any partial receive cell is abandoned.
- R12: After good signal returns, bytes are stored only from the next `ln_rx_sop` byte onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both directions |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit byte enable from ATM layer |
| tx_soc | input | 1 | Transmit start of cell, with byte 0 |
| tx_data | input | 8 | Transmit byte |
| tx_par | input | 1 | Odd parity of `tx_data` |
| tx_cav | output | 1 | Room for one whole transmit cell |
| ln_tx_valid | output | 1 | Line-side transmit byte offered |
| ln_tx_ready | input | 1 | Line side accepts the byte |
| ln_tx_data | output | 8 | Line-side transmit byte |
| ln_tx_sop | output | 1 | Offered byte is byte 0 of a cell |
| ln_rx_valid | input | 1 | Line-side receive byte offered |
| ln_rx_ready | output | 1 | Block accepts the receive byte |
| ln_rx_data | input | 8 | Line-side receive byte |
| ln_rx_sop | input | 1 | Receive byte is byte 0 of a cell |
| sig_good | input | 1 | Line signal is valid; low disables receive storage |
| rx_en | input | 1 | ATM layer takes a receive byte |
| rx_data | output | 8 | Receive byte to ATM layer |
| rx_soc | output | 1 | Receive start of cell |
| rx_par | output | 1 | Odd parity of `rx_data` |
| rx_cav | output | 1 | A whole unstarted receive cell is held |
| par_irq_en | input | 1 | Enables parity interrupt request |
| par_err | output | 1 | Sticky transmit parity error |
| runt_seen | output | 1 | Sticky truncated-cell indication |
| irq | output | 1 | Interrupt request |

## Verification
Storage and both cell-available flags update on the edge that takes a byte. The bench therefore drives each byte at a falling edge and checks `tx_cav`, `rx_cav` and `ln_rx_ready` at the next falling edge, before it drives the following byte. Line-side transmit outputs are combinational from stored state, so each offered byte is compared in the same half-cycle in which `ln_tx_ready` is raised. `rx_data`, `rx_soc` and `rx_par` are registered and are due one edge after `rx_en`. The bench keeps a byte-level model of what the next falling edge must show, whether or not `rx_en` was high. `irq` is combinational and is checked just after `par_irq_en` changes.

// File: rtl/utopia_pkg.sv
package utopia_pkg;
  localparam int CELL_LEN   = 53;
  localparam int CELL_SLOTS = 3;
  localparam int BYTE_W     = 8;

  function automatic logic odd_par(input logic [BYTE_W-1:0] d);
    return ~^d;
  endfunction
endpackage

// File: rtl/cell_fifo.sv
module cell_fifo #(
  parameter int CB        = 53,
  parameter int DC        = 3,
  parameter int W         = 8,
  parameter bit ROOM_FLAG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_valid,
  input  logic         wr_sof,
  input  logic         wr_abort,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic         runt,
  output logic         flag,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         rd_sof,
  input  logic         rd_take
);
  localparam int TOTAL = CB * DC;
  localparam int AW    = $clog2(TOTAL);
  localparam int IW    = $clog2(CB);
  localparam int SLW   = (DC > 1) ? $clog2(DC) : 1;
  localparam int CW    = $clog2(DC + 1);

  logic [W-1:0]   mem [TOTAL];
  logic [SLW-1:0] wr_slot, rd_slot;
  logic [IW-1:0]  wr_idx, rd_idx, idx_use;
  logic           in_cell;
  logic [CW-1:0]  cnt;
  logic           space, start, cont, store, commit, finish;
  logic [AW-1:0]  wr_addr, rd_addr;

  function automatic logic [SLW-1:0] next_slot(input logic [SLW-1:0] s);
    return (s == SLW'(DC - 1)) ? '0 : s + 1'b1;
  endfunction

  always_comb begin
    space    = cnt < CW'(DC);
    start    = wr_valid && wr_sof && !wr_abort;
    cont     = wr_valid && !wr_sof && in_cell && !wr_abort;
    store    = (start || cont) && space;
    idx_use  = start ? '0 : wr_idx;
    commit   = store && (idx_use == IW'(CB - 1));
    runt     = start && in_cell;
    wr_ready = wr_abort || space;
    rd_valid = cnt != '0;
    finish   = rd_take && rd_valid && (rd_idx == IW'(CB - 1));
    wr_addr  = AW'(wr_slot) * AW'(CB) + AW'(idx_use);
    rd_addr  = AW'(rd_slot) * AW'(CB) + AW'(rd_idx);
    rd_data  = mem[rd_addr];
    rd_sof   = rd_idx == '0;
  end

  always_ff @(posedge clk) begin
    if (store) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_slot <= '0;
      wr_idx  <= '0;
      in_cell <= 1'b0;
    end else if (wr_abort) begin
      wr_idx  <= '0;
      in_cell <= 1'b0;
    end else if (store) begin
      if (commit) begin
        wr_idx  <= '0;
        in_cell <= 1'b0;
        wr_slot <= next_slot(wr_slot);
      end else begin
        wr_idx  <= idx_use + 1'b1;
        in_cell <= 1'b1;
      end
    end else if (start) begin
      wr_idx  <= '0;
      in_cell <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_slot <= '0;
      rd_idx  <= '0;
    end else if (rd_take && rd_valid) begin
      if (finish) begin
        rd_idx  <= '0;
        rd_slot <= next_slot(rd_slot);
      end else begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + CW'(commit) - CW'(finish);
  end

  generate
    if (ROOM_FLAG) begin : g_room
      assign flag = (cnt + CW'(in_cell)) < CW'(DC);
    end else begin : g_avail
      logic [CW-1:0] whole;
      assign whole = cnt - CW'(rd_idx != '0);
      assign flag  = whole != '0;
    end
  endgenerate
endmodule

// File: rtl/cell_status.sv
module cell_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chk_en,
  input  logic [W-1:0] data,
  input  logic         par,
  input  logic         runt_a,
  input  logic         runt_b,
  input  logic         irq_en,
  output logic         par_err,
  output logic         runt_seen,
  output logic         irq
);
  import utopia_pkg::*;
  logic bad;

  always_comb begin
    bad = chk_en && (par != odd_par(data));
    irq = par_err && irq_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      par_err   <= 1'b0;
      runt_seen <= 1'b0;
    end else begin
      if (bad)             par_err   <= 1'b1;
      if (runt_a || runt_b) runt_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_out_stage.sv
module rx_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rx_en,
  input  logic         src_valid,
  input  logic [W-1:0] src_data,
  input  logic         src_sof,
  output logic         take,
  output logic [W-1:0] rx_data,
  output logic         rx_soc,
  output logic         rx_par
);
  import utopia_pkg::*;

  assign take = rx_en && src_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_soc  <= 1'b0;
      rx_par  <= 1'b1;
    end else if (take) begin
      rx_data <= src_data;
      rx_soc  <= src_sof;
      rx_par  <= odd_par(src_data);
    end
  end
endmodule

// File: rtl/utopia_cell_if.sv
module utopia_cell_if #(
  parameter int CB = utopia_pkg::CELL_LEN,
  parameter int DC = utopia_pkg::CELL_SLOTS,
  parameter int W  = utopia_pkg::BYTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tx_en,
  input  logic         tx_soc,
  input  logic [W-1:0] tx_data,
  input  logic         tx_par,
  output logic         tx_cav,
  output logic         ln_tx_valid,
  input  logic         ln_tx_ready,
  output logic [W-1:0] ln_tx_data,
  output logic         ln_tx_sop,
  input  logic         ln_rx_valid,
  output logic         ln_rx_ready,
  input  logic [W-1:0] ln_rx_data,
  input  logic         ln_rx_sop,
  input  logic         sig_good,
  input  logic         rx_en,
  output logic [W-1:0] rx_data,
  output logic         rx_soc,
  output logic         rx_par,
  output logic         rx_cav,
  input  logic         par_irq_en,
  output logic         par_err,
  output logic         runt_seen,
  output logic         irq
);
  logic         tx_acc, tx_runt, rx_runt;
  logic         rxq_valid, rxq_sof, rxq_take;
  logic [W-1:0] rxq_data;

  cell_fifo #(.CB(CB), .DC(DC), .W(W), .ROOM_FLAG(1'b1)) u_txq (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (tx_en),
    .wr_sof   (tx_soc),
    .wr_abort (1'b0),
    .wr_data  (tx_data),
    .wr_ready (tx_acc),
    .runt     (tx_runt),
    .flag     (tx_cav),
    .rd_valid (ln_tx_valid),
    .rd_data  (ln_tx_data),
    .rd_sof   (ln_tx_sop),
    .rd_take  (ln_tx_ready)
  );

  cell_fifo #(.CB(CB), .DC(DC), .W(W), .ROOM_FLAG(1'b0)) u_rxq (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (ln_rx_valid),
    .wr_sof   (ln_rx_sop),
    .wr_abort (!sig_good),
    .wr_data  (ln_rx_data),
    .wr_ready (ln_rx_ready),
    .runt     (rx_runt),
    .flag     (rx_cav),
    .rd_valid (rxq_valid),
    .rd_data  (rxq_data),
    .rd_sof   (rxq_sof),
    .rd_take  (rxq_take)
  );

  rx_out_stage #(.W(W)) u_rxo (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .src_valid (rxq_valid),
    .src_data  (rxq_data),
    .src_sof   (rxq_sof),
    .take      (rxq_take),
    .rx_data   (rx_data),
    .rx_soc    (rx_soc),
    .rx_par    (rx_par)
  );

  cell_status #(.W(W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .chk_en    (tx_en && tx_acc),
    .data      (tx_data),
    .par       (tx_par),
    .runt_a    (tx_runt),
    .runt_b    (rx_runt),
    .irq_en    (par_irq_en),
    .par_err   (par_err),
    .runt_seen (runt_seen),
    .irq       (irq)
  );
endmodule

// File: rtl/utopia_cell_if_chk.sv
module utopia_cell_if_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tx_cav,
  input logic         ln_tx_valid,
  input logic         ln_tx_ready,
  input logic [W-1:0] ln_tx_data,
  input logic         ln_tx_sop,
  input logic         ln_rx_ready,
  input logic         sig_good,
  input logic         rx_en,
  input logic [W-1:0] rx_data,
  input logic         rx_soc,
  input logic         rx_par,
  input logic         rx_cav,
  input logic         par_irq_en,
  input logic         par_err,
  input logic         runt_seen,
  input logic         irq
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tx_cav && !rx_cav && !ln_tx_valid && !par_err && !runt_seen));

  a_r6_line_hold: assert property (@(posedge clk) disable iff (rst)
    (ln_tx_valid && !ln_tx_ready) |=> (ln_tx_valid && $stable(ln_tx_data) && $stable(ln_tx_sop)));

  a_r10_rx_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> ($stable(rx_data) && $stable(rx_soc) && $stable(rx_par)));

  a_r10_rx_parity: assert property (@(posedge clk) disable iff (rst)
    (^{rx_data, rx_par}) == 1'b1);

  a_r11_lost_ready: assert property (@(posedge clk) disable iff (rst)
    !sig_good |-> ln_rx_ready);

  a_r5_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> (par_err && par_irq_en));

  a_r5_par_sticky: assert property (@(posedge clk) disable iff (rst)
    par_err |=> par_err);

  a_r4_runt_sticky: assert property (@(posedge clk) disable iff (rst)
    runt_seen |=> runt_seen);
endmodule

bind utopia_cell_if utopia_cell_if_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_cav      (tx_cav),
  .ln_tx_valid (ln_tx_valid),
  .ln_tx_ready (ln_tx_ready),
  .ln_tx_data  (ln_tx_data),
  .ln_tx_sop   (ln_tx_sop),
  .ln_rx_ready (ln_rx_ready),
  .sig_good    (sig_good),
  .rx_en       (rx_en),
  .rx_data     (rx_data),
  .rx_soc      (rx_soc),
  .rx_par      (rx_par),
  .rx_cav      (rx_cav),
  .par_irq_en  (par_irq_en),
  .par_err     (par_err),
  .runt_seen   (runt_seen),
  .irq         (irq)
);

// File: tb/utopia_cell_if_tb.sv
`timescale 1ns/1ps
module utopia_cell_if_tb;
  localparam int CB = 53;
  localparam int DC = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       tx_en = 0, tx_soc = 0, tx_par = 0;
  logic [7:0] tx_data = '0;
  logic       tx_cav, ln_tx_valid, ln_tx_sop, ln_rx_ready;
  logic       ln_tx_ready = 0;
  logic [7:0] ln_tx_data;
  logic       ln_rx_valid = 0, ln_rx_sop = 0, sig_good = 1, rx_en = 0, par_irq_en = 0;
  logic [7:0] ln_rx_data = '0;
  logic [7:0] rx_data;
  logic       rx_soc, rx_par, rx_cav, par_err, runt_seen, irq;

  int  nchk = 0, nfail = 0;
  bit  done = 0;

  utopia_cell_if u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_soc(tx_soc), .tx_data(tx_data),
    .tx_par(tx_par), .tx_cav(tx_cav), .ln_tx_valid(ln_tx_valid),
    .ln_tx_ready(ln_tx_ready), .ln_tx_data(ln_tx_data), .ln_tx_sop(ln_tx_sop),
    .ln_rx_valid(ln_rx_valid), .ln_rx_ready(ln_rx_ready), .ln_rx_data(ln_rx_data),
    .ln_rx_sop(ln_rx_sop), .sig_good(sig_good), .rx_en(rx_en), .rx_data(rx_data),
    .rx_soc(rx_soc), .rx_par(rx_par), .rx_cav(rx_cav), .par_irq_en(par_irq_en),
    .par_err(par_err), .runt_seen(runt_seen), .irq(irq)
  );

  function automatic logic [7:0] pat(input int c, input int b);
    return 8'((c * 37 + b * 5 + 1) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1; tx_en = 0; tx_soc = 0; ln_tx_ready = 0; ln_rx_valid = 0;
    ln_rx_sop = 0; rx_en = 0; sig_good = 1; par_irq_en = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic check_reset_state;
    chk("R1 tx_cav", tx_cav, 1);
    chk("R1 rx_cav", rx_cav, 0);
    chk("R1 ln_tx_valid", ln_tx_valid, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 rx_soc", rx_soc, 0);
    chk("R1 rx_par", rx_par, 1);
    chk("R1 par_err", par_err, 0);
    chk("R1 runt_seen", runt_seen, 0);
  endtask

  task automatic tx_drive(input bit soc, input logic [7:0] d, input bit bad);
    @(negedge clk);
    tx_en = 1; tx_soc = soc; tx_data = d; tx_par = (~^d) ^ bad;
  endtask

  task automatic tx_stop;
    @(negedge clk);
    tx_en = 0; tx_soc = 0;
  endtask

  task automatic drain(input int c0, input int n, input string req);
    int pos = 0;
    bit stall = 0;
    logic [7:0] held = '0;
    for (int k = 0; k < 3000 && pos < n * CB; k++) begin
      @(negedge clk);
      if (stall) chk("R6 hold while stalled", ln_tx_data, held);
      ln_tx_ready = (k % 3 != 1);
      if (ln_tx_ready && ln_tx_valid) begin
        chk({req, " data"}, ln_tx_data, pat(c0 + pos / CB, pos % CB));
        chk({req, " sop"}, ln_tx_sop, (pos % CB == 0) ? 1 : 0);
        pos++;
      end
      stall = ln_tx_valid && !ln_tx_ready;
      held  = ln_tx_data;
    end
    @(negedge clk);
    ln_tx_ready = 0;
    chk({req, " byte count"}, pos, n * CB);
    chk({req, " empty after"}, ln_tx_valid, 0);
  endtask

  task automatic ln_put(input bit sop, input logic [7:0] d, input int exp_rdy, input string req);
    @(negedge clk);
    chk(req, ln_rx_ready, exp_rdy);
    ln_rx_valid = 1; ln_rx_sop = sop; ln_rx_data = d;
  endtask

  task automatic ln_stop;
    @(negedge clk);
    ln_rx_valid = 0; ln_rx_sop = 0;
  endtask

  task automatic rx_read(input int c0, input int n);
    int r = 0;
    int extra = 0;
    logic [7:0] ed = rx_data;
    logic       es = rx_soc;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      chk("R10 rx_data", rx_data, ed);
      chk("R10 rx_soc", rx_soc, es);
      chk("R10 rx_par", rx_par, ~^ed);
      chk("R9 rx_cav", rx_cav, ((n - (r + CB - 1) / CB) > 0) ? 1 : 0);
      if (extra >= 4) break;
      if (r == n * CB) begin
        rx_en = 1; extra++;
      end else begin
        rx_en = (k % 4 != 2);
        if (rx_en) begin
          ed = pat(c0 + r / CB, r % CB);
          es = (r % CB == 0);
          r++;
        end
      end
    end
    rx_en = 0;
    chk("R10 bytes read", r, n * CB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int full;
    do_reset();
    check_reset_state();

    // R3/R7: fill transmit side with line stalled, sweeping tx_cav per byte
    full = 0;
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < CB; b++) begin
        @(negedge clk);
        chk("R3 tx_cav", tx_cav, ((full + ((b > 0 && full < DC) ? 1 : 0)) < DC) ? 1 : 0);
        chk("R2 valid only after whole cell", ln_tx_valid, (full > 0) ? 1 : 0);
        tx_en = 1; tx_soc = (b == 0); tx_data = pat(c, b); tx_par = ~^pat(c, b);
      end
      if (full < DC) full++;
    end
    tx_stop();
    chk("R3 tx_cav full", tx_cav, 0);
    drain(0, 3, "R2/R7 tx stream");
    chk("R3 tx_cav after drain", tx_cav, 1);

    // R4: hunting bytes dropped, runt discarded
    for (int b = 0; b < 3; b++) tx_drive(0, pat(9, b), 0);
    for (int b = 0; b < 10; b++) tx_drive(b == 0, pat(10, b), 0);
    tx_stop();
    chk("R4 no runt yet", runt_seen, 0);
    chk("R4 partial not offered", ln_tx_valid, 0);
    for (int b = 0; b < CB; b++) tx_drive(b == 0, pat(11, b), 0);
    tx_stop();
    chk("R4 runt_seen", runt_seen, 1);
    drain(11, 1, "R4 tx after runt");

    // R5: parity error flagged, cell delivered
    chk("R5 par_err clear", par_err, 0);
    for (int b = 0; b < CB; b++) tx_drive(b == 0, pat(20, b), b == 5);
    tx_stop();
    chk("R5 par_err set", par_err, 1);
    chk("R5 irq masked", irq, 0);
    par_irq_en = 1;
    #1;
    chk("R5 irq enabled", irq, 1);
    drain(20, 1, "R5 tx bad parity cell");
    do_reset();
    check_reset_state();
    chk("R1 irq after reset", irq, 0);

    // R8/R9/R10: receive fill then read out
    full = 0;
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < CB; b++) begin
        ln_put(b == 0, pat(30 + c, b), (full < DC) ? 1 : 0, "R8 ln_rx_ready");
        chk("R9 rx_cav fill", rx_cav, (full > 0) ? 1 : 0);
      end
      if (full < DC) full++;
    end
    ln_stop();
    chk("R8 ready low when full", ln_rx_ready, 0);
    rx_read(30, 3);
    chk("R8 ready after read", ln_rx_ready, 1);

    // R11/R12: signal loss drops data, resync on next sop
    do_reset();
    for (int b = 0; b < 20; b++) ln_put(b == 0, pat(40, b), 1, "R8 ready partial");
    @(negedge clk);
    ln_rx_valid = 0; sig_good = 0;
    for (int b = 0; b < 40; b++) ln_put(b == 0, pat(50, b), 1, "R11 ready while lost");
    ln_stop();
    chk("R11 nothing held", rx_cav, 0);
    sig_good = 1;
    for (int b = 0; b < 5; b++) ln_put(0, pat(60, b), 1, "R12 ready");
    for (int b = 0; b < CB; b++) ln_put(b == 0, pat(41, b), 1, "R12 ready cell");
    ln_stop();
    chk("R12 one cell held", rx_cav, 1);
    rx_read(41, 1);
    chk("R12 no stray cell", rx_cav, 0);
    chk("R4 rx no runt", runt_seen, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule